// File: doc/BRIEF.md
# Programmable line pulse shape sequencer

This block generates the digital amplitude sequence for the transmit side of a T1 or E1 line interface. Each bit period is split into 32 sub-clock phases, and the block emits one signed DAC code per phase. A mark is drawn from a per-mode template of ordered segments. For T1 these are overshoot, plateau, falling edge and three undershoot tails. For E1 they are overshoot and plateau, followed by zero. A space produces zero for the whole period. Marks alternate in polarity, and a negative mark is the exact negation of a positive one.

Software tunes the shape through a small write port. There are four segment registers, A to D. Each holds a sign-magnitude level trim and a sign-magnitude boundary shift. A fifth register, E, holds the trim for the last undershoot tail and a 4-bit gain code. The gain code scales every level, trims included. The scaled result saturates symmetrically to the DAC range.

Register and mode changes are copied into a working set only at the bit-period boundary. As a result, every pulse is built from one consistent configuration.

Top module: `lps_shaper`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads as zero, `code_o` is 0, and `period_end_o` is 1. The first period after reset is a space.
- R2: A bit period lasts 32 clocks. `period_end_o` is high only in the last clock of each period. `data_bit_i` is sampled at the clock edge that ends that clock, and the codes for that bit appear on the next 32 clocks, phase 0 first.
- R3: A space (data 0) gives code 0 for all 32 phases. Marks alternate polarity, and the first mark after reset is positive. A negative mark outputs the negation of every code the positive mark would give. A space does not change the polarity sequence.
- R4: The T1 nominal template uses boundaries at phases 3, 14, 17, 21 and 27. Its base levels are 100 (overshoot), 80 (plateau), 24 (falling), -20, -12 and -6 (the three undershoot tails).
- R5: `wr_sel_i` values 0 to 4 select registers A to E. Values 5 to 7 write nothing.
- R6: In registers A to D, bits 7:3 hold a level trim: bit 7 is the sign and bits 6:3 are the magnitude. In register E, bits 7:4 hold the third-tail trim: bit 7 is the sign and bits 6:4 are the magnitude. A trim adds to the base level of its segment in code units. Negative zero acts as zero.
- R7: In registers A to D, bits 2:0 hold a boundary shift: bit 2 is the sign and bits 1:0 are the magnitude, in whole phases. A moves overshoot to plateau, B moves plateau to falling, C moves tail 1 to tail 2, and D moves tail 2 to tail 3.
- R8: Register E bits 3:0 select a gain. Codes 1 to 7 give +2.67, +5.34, +8.67, +11.34, +14.0, +17.34 and +20.97 %. Codes 8 to 15 give -2.1, -4, -6, -8, -10, -12, -14 and -15.34 %. Code 0 is nominal. The factor is round(1024*(1+g)), and the output is floor((level*factor+512)/1024).
- R9: Scaled codes saturate to the range -127 to +127. The code -128 never appears.
- R10: In E1 mode, the boundaries are 4 and 16 and the levels are 110 and 90, with zero after the plateau. Only A and B take effect; C, D and E (gain included) are ignored.
- R11: Register writes and `mode_e1_i` changes made during a period do not alter that period's codes. They apply from the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock, 32 per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_e1_i | input | 1 | 1 selects the E1 template, 0 selects T1 |
| data_bit_i | input | 1 | Line bit, sampled at period end |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select, 0..4 = A..E |
| wr_data_i | input | 8 | Register write data |
| period_end_o | output | 1 | High during the last phase of a period |
| code_o | output | 8 | Signed DAC code for the current phase |

## Verification
The bench targets the places where a shifted boundary lands, phase by phase. A design that applied a shift to the wrong edge, or compared with the wrong inclusive bound, would emit the neighbouring segment's level for exactly one phase. The bench uses sign-magnitude fields with negative values and a negative zero. A design that used two's complement would produce trims and shifts that are wildly wrong.

Saturation is driven with the largest trim at the highest gain, in both polarities. A design that clipped asymmetrically, or negated after wrapping, would emit -128 or a wrapped value.

The bench also writes mid-pulse, changes the mode mid-pulse, writes to unused selects, and programs registers C to E in E1 mode. These catch a design that loads settings live, decodes select values loosely, or lets the tail registers leak into E1.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int BASE_PH = 32;
  localparam int NREG    = 5;
  localparam int LVL_W   = 10;
  localparam int FRAC_W  = 10;
  localparam int FAC_W   = 12;

  typedef logic signed [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic [4:0] trim;
    logic [2:0] shift;
  } seg_reg_t;

  typedef struct packed {
    logic [3:0] trim;
    logic [3:0] gain;
  } tail_reg_t;

  typedef struct packed {
    logic           e1;
    seg_reg_t [3:0] seg;   // index 0 = A .. 3 = D
    tail_reg_t      tail;
  } cfg_t;

  typedef enum logic [2:0] {
    SEG_OVR, SEG_PLAT, SEG_FALL, SEG_UND1, SEG_UND2, SEG_UND3, SEG_IDLE
  } seg_e;

  // nominal template, in 1/32 bit units and code units
  localparam lvl_t T1_B1 = 10'sd3;
  localparam lvl_t T1_B2 = 10'sd14;
  localparam lvl_t T1_B3 = 10'sd17;
  localparam lvl_t T1_B4 = 10'sd21;
  localparam lvl_t T1_B5 = 10'sd27;
  localparam lvl_t E1_B1 = 10'sd4;
  localparam lvl_t E1_B2 = 10'sd16;

  localparam lvl_t T1_L_OVR  = 10'sd100;
  localparam lvl_t T1_L_PLAT = 10'sd80;
  localparam lvl_t T1_L_FALL = 10'sd24;
  localparam lvl_t T1_L_UND1 = -10'sd20;
  localparam lvl_t T1_L_UND2 = -10'sd12;
  localparam lvl_t T1_L_UND3 = -10'sd6;
  localparam lvl_t E1_L_OVR  = 10'sd110;
  localparam lvl_t E1_L_PLAT = 10'sd90;

  function automatic lvl_t sm5(input logic [4:0] f);
    lvl_t m;
    m = lvl_t'(f[3:0]);
    return f[4] ? -m : m;
  endfunction

  function automatic lvl_t sm4(input logic [3:0] f);
    lvl_t m;
    m = lvl_t'(f[2:0]);
    return f[3] ? -m : m;
  endfunction

  function automatic lvl_t sm3(input logic [2:0] f);
    lvl_t m;
    m = lvl_t'(f[1:0]);
    return f[2] ? -m : m;
  endfunction

  // gain factor in 1/1024 units
  function automatic logic [FAC_W-1:0] gain_factor(input logic [3:0] code);
    case (code)
      4'd0:    return 12'd1024;
      4'd1:    return 12'd1051;
      4'd2:    return 12'd1079;
      4'd3:    return 12'd1113;
      4'd4:    return 12'd1140;
      4'd5:    return 12'd1167;
      4'd6:    return 12'd1202;
      4'd7:    return 12'd1239;
      4'd8:    return 12'd1002;
      4'd9:    return 12'd983;
      4'd10:   return 12'd963;
      4'd11:   return 12'd942;
      4'd12:   return 12'd922;
      4'd13:   return 12'd901;
      4'd14:   return 12'd881;
      default: return 12'd867;
    endcase
  endfunction
endpackage

// File: rtl/lps_phase_ctr.sv
module lps_phase_ctr #(
  parameter int PHASES = 32,
  localparam int PH_W  = $clog2(PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] ph_q;

  // reset parks on the last phase so the first edge opens a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ph_q <= PH_LAST;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                      ph_q <= ph_q + 1'b1;
  end

  assign phase_o = ph_q;
  assign last_o  = (ph_q == PH_LAST);
endmodule

// File: rtl/lps_cfg_regs.sv
module lps_cfg_regs
  import lps_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       mode_e1_i,
  input  logic       load_i,
  output cfg_t       cfg_o
);
  logic [7:0] live_q [NREG];
  cfg_t       cfg_q;

  for (genvar i = 0; i < NREG; i++) begin : g_live
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 live_q[i] <= '0;
      else if (wr_en_i && (wr_sel_i == 3'(i)))     live_q[i] <= wr_data_i;
    end
  end

  // working copy, refreshed only at the period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (load_i) begin
      cfg_q.e1 <= mode_e1_i;
      for (int i = 0; i < 4; i++) cfg_q.seg[i] <= seg_reg_t'(live_q[i]);
      cfg_q.tail <= tail_reg_t'(live_q[NREG-1]);
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/lps_seg_sel.sv
module lps_seg_sel
  import lps_pkg::*;
#(
  parameter int PHASES = 32,
  localparam int PH_W  = $clog2(PHASES)
) (
  input  cfg_t            cfg_i,
  input  logic [PH_W-1:0] phase_i,
  output lvl_t            lvl_o,
  output logic [3:0]      gain_o
);
  localparam lvl_t SC = lvl_t'(PHASES / BASE_PH);

  lvl_t ph_s, b1, b2, b3, b4, b5;
  seg_e seg;

  always_comb begin
    ph_s = lvl_t'(phase_i);
    if (cfg_i.e1) begin
      b1 = (E1_B1 + sm3(cfg_i.seg[0].shift)) * SC;
      b2 = (E1_B2 + sm3(cfg_i.seg[1].shift)) * SC;
      b3 = b2;
      b4 = b2;
      b5 = b2;
    end else begin
      b1 = (T1_B1 + sm3(cfg_i.seg[0].shift)) * SC;
      b2 = (T1_B2 + sm3(cfg_i.seg[1].shift)) * SC;
      b3 = T1_B3 * SC;
      b4 = (T1_B4 + sm3(cfg_i.seg[2].shift)) * SC;
      b5 = (T1_B5 + sm3(cfg_i.seg[3].shift)) * SC;
    end

    if      (ph_s < b1) seg = SEG_OVR;
    else if (ph_s < b2) seg = SEG_PLAT;
    else if (cfg_i.e1)  seg = SEG_IDLE;
    else if (ph_s < b3) seg = SEG_FALL;
    else if (ph_s < b4) seg = SEG_UND1;
    else if (ph_s < b5) seg = SEG_UND2;
    else                seg = SEG_UND3;

    case (seg)
      SEG_OVR:  lvl_o = (cfg_i.e1 ? E1_L_OVR  : T1_L_OVR)  + sm5(cfg_i.seg[0].trim);
      SEG_PLAT: lvl_o = (cfg_i.e1 ? E1_L_PLAT : T1_L_PLAT) + sm5(cfg_i.seg[1].trim);
      SEG_FALL: lvl_o = T1_L_FALL;
      SEG_UND1: lvl_o = T1_L_UND1 + sm5(cfg_i.seg[2].trim);
      SEG_UND2: lvl_o = T1_L_UND2 + sm5(cfg_i.seg[3].trim);
      SEG_UND3: lvl_o = T1_L_UND3 + sm4(cfg_i.tail.trim);
      default:  lvl_o = '0;
    endcase

    gain_o = cfg_i.e1 ? 4'd0 : cfg_i.tail.gain;
  end
endmodule

// File: rtl/lps_gain_sat.sv
module lps_gain_sat
  import lps_pkg::*;
#(
  parameter int DAC_W = 8
) (
  input  lvl_t                    lvl_i,
  input  logic [3:0]              gain_i,
  input  logic                    mark_i,
  input  logic                    neg_i,
  output logic signed [DAC_W-1:0] code_o
);
  localparam int PROD_W = LVL_W + FAC_W + 1;
  typedef logic signed [PROD_W-1:0] prod_t;
  localparam prod_t RND  = prod_t'(2 ** (FRAC_W - 1));
  localparam prod_t MAXV = prod_t'(2 ** (DAC_W - 1) - 1);

  prod_t                    prod, scaled;
  logic signed [DAC_W-1:0]  mag;

  always_comb begin
    prod   = prod_t'(lvl_i) * prod_t'(gain_factor(gain_i));
    scaled = (prod + RND) >>> FRAC_W;
    // symmetric clip keeps negation in range
    if      (scaled >  MAXV) mag = DAC_W'(MAXV);
    else if (scaled < -MAXV) mag = DAC_W'(-MAXV);
    else                     mag = DAC_W'(scaled);
    if (!mark_i)     code_o = '0;
    else if (neg_i)  code_o = -mag;
    else             code_o = mag;
  end
endmodule

// File: rtl/lps_shaper.sv
module lps_shaper
  import lps_pkg::*;
#(
  parameter int PHASES = 32,
  parameter int DAC_W  = 8,
  localparam int PH_W  = $clog2(PHASES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_e1_i,
  input  logic             data_bit_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [7:0]       wr_data_i,
  output logic             period_end_o,
  output logic [DAC_W-1:0] code_o
);
  logic [PH_W-1:0]         phase;
  logic                    last;
  cfg_t                    cfg_sh;
  lvl_t                    lvl;
  logic [3:0]              gain;
  logic                    mark_q, neg_q;
  logic signed [DAC_W-1:0] code;

  lps_phase_ctr #(.PHASES(PHASES)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .last_o  (last)
  );

  lps_cfg_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .mode_e1_i (mode_e1_i),
    .load_i    (last),
    .cfg_o     (cfg_sh)
  );

  // alternate mark inversion; neg_q starts set so the first mark is positive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mark_q <= 1'b0;
      neg_q  <= 1'b1;
    end else if (last) begin
      mark_q <= data_bit_i;
      if (data_bit_i) neg_q <= ~neg_q;
    end
  end

  lps_seg_sel #(.PHASES(PHASES)) u_seg (
    .cfg_i   (cfg_sh),
    .phase_i (phase),
    .lvl_o   (lvl),
    .gain_o  (gain)
  );

  lps_gain_sat #(.DAC_W(DAC_W)) u_gain (
    .lvl_i  (lvl),
    .gain_i (gain),
    .mark_i (mark_q),
    .neg_i  (neg_q),
    .code_o (code)
  );

  assign period_end_o = last;
  assign code_o       = code;
endmodule

// File: rtl/lps_shaper_chk.sv
module lps_shaper_chk
  import lps_pkg::*;
#(
  parameter int PHASES = 32,
  parameter int DAC_W  = 8,
  localparam int PH_W  = $clog2(PHASES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             data_bit_i,
  input logic             period_end_o,
  input logic [DAC_W-1:0] code_o,
  input logic [PH_W-1:0]  phase,
  input logic             mark_q,
  input logic             neg_q,
  input cfg_t             cfg_sh
);
  localparam int E1_TAIL = (int'(E1_B2) + 3) * (PHASES / BASE_PH);

  // R2
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_o |=> (phase == $past(phase) + 1'b1));

  // R2
  period_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |=> (phase == '0) && !period_end_o);

  // R3
  space_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mark_q |-> (code_o == '0));

  // R3
  ami_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_end_o && data_bit_i) |=> (neg_q != $past(neg_q)));

  // R9
  no_min_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o != {1'b1, {(DAC_W-1){1'b0}}});

  // R10
  e1_tail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sh.e1 && (int'(phase) >= E1_TAIL)) |-> (code_o == '0));

  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_o |=> $stable(cfg_sh));
endmodule

bind lps_shaper lps_shaper_chk #(.PHASES(PHASES), .DAC_W(DAC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .data_bit_i   (data_bit_i),
  .period_end_o (period_end_o),
  .code_o       (code_o),
  .phase        (phase),
  .mark_q       (mark_q),
  .neg_q        (neg_q),
  .cfg_sh       (cfg_sh)
);

// File: tb/sim_lps_shaper.sv
`timescale 1ns/1ps
module sim_lps_shaper;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_e1_i = 1'b0;
  logic       data_bit_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       period_end_o;
  logic [7:0] code_o;

  int n_chk = 0, n_fail = 0;
  int breg [5];
  bit bneg = 1'b1;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  lps_shaper u0 (.*);

  real gpct [16] = '{0.0, 0.0267, 0.0534, 0.0867, 0.1134, 0.14, 0.1734, 0.2097,
                     -0.021, -0.04, -0.06, -0.08, -0.10, -0.12, -0.14, -0.1534};

  function automatic int smv(int f, int w);
    int m = f & ((1 << (w - 1)) - 1);
    return ((f >> (w - 1)) & 1) ? -m : m;
  endfunction

  function automatic int exp_code(bit e1, int r[5], bit mark, bit neg, int k);
    int lvl, f, v, b1, b2, b4, b5;
    if (!mark) return 0;
    if (e1) begin
      b1 = 4 + smv(r[0] & 7, 3);
      b2 = 16 + smv(r[1] & 7, 3);
      if      (k < b1) lvl = 110 + smv(r[0] >> 3, 5);
      else if (k < b2) lvl = 90 + smv(r[1] >> 3, 5);
      else             lvl = 0;
      f = 1024;
    end else begin
      b1 = 3 + smv(r[0] & 7, 3);
      b2 = 14 + smv(r[1] & 7, 3);
      b4 = 21 + smv(r[2] & 7, 3);
      b5 = 27 + smv(r[3] & 7, 3);
      if      (k < b1) lvl = 100 + smv(r[0] >> 3, 5);
      else if (k < b2) lvl = 80 + smv(r[1] >> 3, 5);
      else if (k < 17) lvl = 24;
      else if (k < b4) lvl = -20 + smv(r[2] >> 3, 5);
      else if (k < b5) lvl = -12 + smv(r[3] >> 3, 5);
      else             lvl = -6 + smv(r[4] >> 4, 4);
      f = $rtoi(1024.0 * (1.0 + gpct[r[4] & 15]) + 0.5);
    end
    v = (lvl * f + 512) >>> 10;
    if (v > 127)  v = 127;
    if (v < -127) v = -127;
    return neg ? -v : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 3'(sel); wr_data_i = 8'(data);
    if (sel < 5) breg[sel] = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic clear_regs();
    for (int i = 0; i < 5; i++) wr(i, 0);
  endtask

  // one bit period; optional write (sel, data) and mode flip mid-pulse
  task automatic do_bit(bit b, string req, bit mid = 0, int msel = 0, int mdat = 0,
                        bit mmode = 0);
    int  snap [5];
    bit  smode, sneg;
    while (!period_end_o) @(negedge clk_i);
    data_bit_i = b;
    snap = breg;
    smode = mode_e1_i;
    if (b) bneg = ~bneg;
    sneg = bneg;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk_i);
      if (k == 0) data_bit_i = 1'b0;
      chk(req, $signed(code_o), exp_code(smode, snap, b, sneg, k));
      chk("R2", int'(period_end_o), int'(k == 31));
      if (mid && k == 10) begin
        wr_en_i = 1'b1; wr_sel_i = 3'(msel); wr_data_i = 8'(mdat);
        if (msel < 5) breg[msel] = mdat;
        if (mmode) mode_e1_i = ~mode_e1_i;
      end
      if (k == 11) wr_en_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 5; i++) breg[i] = 0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1", $signed(code_o), 0);
    chk("R1", int'(period_end_o), 1);
    rst_ni = 1'b1;
    do_bit(1'b0, "R1");
  endtask

  task automatic t_t1_nominal();
    do_bit(1'b1, "R4");
    do_bit(1'b1, "R3");
    do_bit(1'b0, "R3");
    do_bit(1'b1, "R3");
  endtask

  task automatic t_trim();
    wr(0, 8'h28);   // A +5
    wr(1, 8'h80);   // B negative zero
    wr(2, 8'h98);   // C -3
    wr(3, 8'h30);   // D +6
    wr(4, 8'hA0);   // E tail -2
    do_bit(1'b1, "R6");
    do_bit(1'b1, "R6");
    clear_regs();
  endtask

  task automatic t_edge();
    wr(0, 8'h07);   // A -3
    wr(1, 8'h03);   // B +3
    wr(2, 8'h06);   // C -2
    wr(3, 8'h01);   // D +1
    do_bit(1'b1, "R7");
    wr(0, 8'h03); wr(1, 8'h05); wr(2, 8'h03); wr(3, 8'h07);
    do_bit(1'b1, "R7");
    clear_regs();
  endtask

  task automatic t_gain();
    wr(4, 8'h07);
    do_bit(1'b1, "R8");
    wr(0, 8'h78);   // A +15 with top gain clips
    do_bit(1'b1, "R9");
    do_bit(1'b1, "R9");
    wr(4, 8'h0F);
    do_bit(1'b1, "R8");
    wr(4, 8'h19);
    do_bit(1'b1, "R8");
    clear_regs();
  endtask

  task automatic t_e1();
    mode_e1_i = 1'b1;
    wr(0, 8'h7F);   // A +15, -3
    wr(1, 8'hC3);   // B -8, +3
    wr(2, 8'h5A); wr(3, 8'hFF); wr(4, 8'h77);
    do_bit(1'b1, "R10");
    do_bit(1'b1, "R10");
    mode_e1_i = 1'b0;
    clear_regs();
  endtask

  task automatic t_midwrite();
    do_bit(1'b1, "R11", 1'b1, 0, 8'h7B, 1'b1);
    do_bit(1'b1, "R11");
    mode_e1_i = 1'b0;
    clear_regs();
  endtask

  task automatic t_badsel();
    wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
    do_bit(1'b1, "R5");
  endtask

  initial begin
    t_reset();
    t_t1_nominal();
    t_trim();
    t_edge();
    t_gain();
    t_e1();
    t_midwrite();
    t_badsel();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule